// File: doc/BRIEF.md
# Power-Down Clock-Change Sequencer

This block sits on the controller side of a DDR2-style memory. A host issues row-precharge and mode-register-load requests, and the block places them on a two-bit command bus. When the host asks for power-down, the block turns on-die termination off. It waits until no bank is open and until the last command has aged long enough. It then drops the clock-enable line.

Once clock enable is low, the host may ask for an input-clock frequency change. The block holds off until clock enable has been low for a settling period. It then raises a go signal to the clock generator and keeps it high until the generator reports completion. An exit request, or the end of a frequency change, raises clock enable again, but not before the minimum low time has passed. While clock enable is low, only no-operation commands appear on the command bus.

All delays are counted in clock cycles and set by parameters. Defaults: row-precharge gap 3, mode-register gap 2, precharge-to-power-down gap 1, settle 2, minimum low time 6.

Top module: `pd_clk_seq`

## Requirements
- R1: After reset the outputs are as follows: `cke` is 1; `odt`, `fchg_go` and `fchg_err` are 0; `cmd` is NOP.
- R2: Command codes on `cmd` are NOP=2'b00, PRE=2'b01 and LMR=2'b10. A request sampled in idle is driven for one cycle, starting the next cycle. A precharge request wins over a mode-load request in the same cycle. `cmd_all` carries the all-bank flag with PRE. `cmd_sel` carries the 2-bit register select with LMR.
- R3: A mode-load request is not acted on until the LMR cycle can be at least T_RP cycles after the last PRE cycle.
- R4: Clock enable falls only under three conditions. `bank_open` must be all zero. The low cycle must be at least T_PRE_PD cycles after a PRE cycle, or at least T_MRD cycles after an LMR cycle. A power-down request in the same cycle as a command request is accepted together with that command.
- R5: In idle, `odt` follows `odt_req` one cycle later. From the cycle after a power-down request, `odt` is 0 until idle is reached again.
- R6: While `cke` is 0, `cmd` is NOP whatever the host requests.
- R7: After a frequency request made in power-down, `fchg_go` rises in the first cycle that is at least T_SETTLE cycles after the first low cycle. It stays high until `fchg_done` is sampled, and is 0 in the next cycle.
- R8: A frequency request made in any state other than settled power-down gives a one-cycle `fchg_err` pulse in the next cycle and changes nothing else.
- R9: Clock enable rises only after T_CKE low cycles have been completed. During a frequency change it rises only after `fchg_done`. An exit request made during a change is ignored.
- R10: An exit request made while waiting for entry cancels the entry, and `cke` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Request power-down entry |
| exit_req | input | 1 | Request power-down exit |
| fchg_req | input | 1 | Request a clock frequency change |
| fchg_done | input | 1 | Clock generator finished the change |
| pre_req | input | 1 | Request a precharge |
| pre_all | input | 1 | Precharge targets all banks |
| mrs_req | input | 1 | Request a mode-register load |
| mrs_sel | input | 2 | Mode register select |
| odt_req | input | 1 | Termination wanted while idle |
| bank_open | input | NBANK | One bit per open bank |
| cmd | output | 2 | Command bus code |
| cmd_all | output | 1 | All-bank flag with PRE |
| cmd_sel | output | 2 | Register select with LMR |
| cke | output | 1 | Clock enable to memory |
| odt | output | 1 | On-die termination enable |
| fchg_go | output | 1 | Frequency change may proceed |
| fchg_err | output | 1 | Frequency request rejected |

## Verification
A command request and a power-down request can be accepted in the same cycle. In that case the fresh command sets the entry gap. The bench provokes this with a mode-load and a power-down request together, and expects `cke` low exactly T_MRD cycles after the LMR cycle. Settling and the minimum low time can also overlap. The bench sends `fchg_done` in the same cycle `fchg_go` first appears, and checks that the exit still waits for the full T_CKE low cycles. A behavioural model keyed on absolute cycle numbers judges every output on every cycle.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_PRE = 2'b01,
    CMD_LMR = 2'b10
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ENTRY,
    ST_PD,
    ST_PD_SETTLE,
    ST_FREQ_CHANGE,
    ST_EXIT
  } st_e;

  // Cycles that must separate a command cycle from the first CKE-low cycle.
  function automatic int unsigned entry_gap(cmd_e k, int unsigned pre_pd,
                                            int unsigned mrd);
    case (k)
      CMD_PRE: return pre_pd;
      CMD_LMR: return mrd;
      default: return 0;
    endcase
  endfunction

  // True when the cycle after the current one is far enough from the command.
  function automatic logic gap_met(int unsigned since, int unsigned need);
    return (since + 1) >= need;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b,
                                       int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pd_gap_tracker.sv
module pd_gap_tracker
  import pd_seq_pkg::*;
#(
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_PRE_PD = 1,
  parameter int GW       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e issued,
  output logic entry_ok,
  output logic lm_ok
);

  localparam logic [GW-1:0] SAT = '1;

  cmd_e          kind_q;
  logic [GW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= CMD_NOP;
      since_q <= SAT;
    end else if (issued != CMD_NOP) begin
      kind_q  <= issued;
      since_q <= '0;
    end else if (since_q != SAT) begin
      since_q <= since_q + 1'b1;
    end
  end

  assign entry_ok = gap_met(32'(since_q),
                            entry_gap(kind_q, T_PRE_PD, T_MRD));
  assign lm_ok    = (kind_q != CMD_PRE) || gap_met(32'(since_q), T_RP);

  // R3
  lm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issued == CMD_LMR) |-> lm_ok);

endmodule

// File: rtl/pd_low_timer.sv
module pd_low_timer #(
  parameter int T_SETTLE = 2,
  parameter int T_CKE    = 6,
  parameter int LW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_q,
  input  logic          cke_fall,
  output logic          settle_ok,
  output logic          lowmin_ok,
  output logic [LW-1:0] low_cycles
);

  localparam logic [LW-1:0] SAT = '1;

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cke_fall) begin
      cnt_q <= LW'(1);
    end else if (!cke_q) begin
      if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign low_cycles = cnt_q;
  assign settle_ok  = int'(cnt_q) >= T_SETTLE;
  assign lowmin_ok  = int'(cnt_q) >= T_CKE;

  // R4
  fall_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_fall |-> cke_q);

endmodule

// File: rtl/pd_ctrl_fsm.sv
module pd_ctrl_fsm
  import pd_seq_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             exit_req,
  input  logic             fchg_req,
  input  logic             fchg_done,
  input  logic             pre_req,
  input  logic             pre_all,
  input  logic             mrs_req,
  input  logic [1:0]       mrs_sel,
  input  logic             odt_req,
  input  logic [NBANK-1:0] bank_open,
  input  logic             entry_ok,
  input  logic             lm_ok,
  input  logic             settle_ok,
  input  logic             lowmin_ok,
  output cmd_e             cmd_d,
  output logic             cke_fall,
  output st_e              state,
  output cmd_e             cmd_q,
  output logic             all_q,
  output logic [1:0]       sel_q,
  output logic             cke_q,
  output logic             odt_q,
  output logic             go_q,
  output logic             err_q
);

  st_e  st_q, st_d;
  logic cke_d, odt_d, go_d, err_d;

  always_comb begin
    st_d     = st_q;
    cmd_d    = CMD_NOP;
    cke_d    = cke_q;
    odt_d    = 1'b0;
    go_d     = go_q;
    err_d    = fchg_req && (st_q != ST_PD);
    cke_fall = 1'b0;
    case (st_q)
      ST_IDLE: begin
        odt_d = odt_req;
        if (pre_req)               cmd_d = CMD_PRE;
        else if (mrs_req && lm_ok) cmd_d = CMD_LMR;
        if (pd_req) begin
          st_d  = ST_WAIT_ENTRY;
          odt_d = 1'b0;
        end
      end
      ST_WAIT_ENTRY: begin
        if (exit_req) begin
          st_d = ST_IDLE;
        end else if ((bank_open == '0) && entry_ok) begin
          st_d     = ST_PD;
          cke_d    = 1'b0;
          cke_fall = 1'b1;
        end
      end
      ST_PD: begin
        if (fchg_req)      st_d = ST_PD_SETTLE;
        else if (exit_req) st_d = ST_EXIT;
      end
      ST_PD_SETTLE: begin
        if (settle_ok) begin
          go_d = 1'b1;
          st_d = ST_FREQ_CHANGE;
        end
      end
      ST_FREQ_CHANGE: begin
        if (fchg_done) begin
          go_d = 1'b0;
          st_d = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (lowmin_ok) begin
          cke_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= CMD_NOP;
      all_q <= 1'b0;
      sel_q <= 2'b00;
      cke_q <= 1'b1;
      odt_q <= 1'b0;
      go_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      all_q <= (cmd_d == CMD_PRE) && pre_all;
      sel_q <= (cmd_d == CMD_LMR) ? mrs_sel : 2'b00;
      cke_q <= cke_d;
      odt_q <= odt_d;
      go_q  <= go_d;
      err_q <= err_d;
    end
  end

  assign state = st_q;

  // R6
  low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> (cmd_q == CMD_NOP));

  // R5
  low_odt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> !odt_q);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(fchg_req));

  // R7
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !fchg_done) |=> go_q);

  // R9
  go_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !cke_q);

endmodule

// File: rtl/pd_clk_seq.sv
module pd_clk_seq
  import pd_seq_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_PRE_PD = 1,
  parameter int T_SETTLE = 2,
  parameter int T_CKE    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             exit_req,
  input  logic             fchg_req,
  input  logic             fchg_done,
  input  logic             pre_req,
  input  logic             pre_all,
  input  logic             mrs_req,
  input  logic [1:0]       mrs_sel,
  input  logic             odt_req,
  input  logic [NBANK-1:0] bank_open,
  output logic [1:0]       cmd,
  output logic             cmd_all,
  output logic [1:0]       cmd_sel,
  output logic             cke,
  output logic             odt,
  output logic             fchg_go,
  output logic             fchg_err
);

  localparam int MAXG = int'(max3(T_RP, T_MRD, T_PRE_PD));
  localparam int GW   = $clog2(MAXG + 2);
  localparam int LW   = $clog2(T_CKE + T_SETTLE + 2);

  cmd_e          cmd_d, cmd_q;
  st_e           state;
  logic          entry_ok, lm_ok, settle_ok, lowmin_ok, cke_fall;
  logic          cke_q, odt_q, go_q, err_q, all_q;
  logic [1:0]    sel_q;
  logic [LW-1:0] low_cycles;

  pd_gap_tracker #(
    .T_RP(T_RP), .T_MRD(T_MRD), .T_PRE_PD(T_PRE_PD), .GW(GW)
  ) u_gap (
    .clk(clk), .rst_n(rst_n), .issued(cmd_d),
    .entry_ok(entry_ok), .lm_ok(lm_ok)
  );

  pd_low_timer #(
    .T_SETTLE(T_SETTLE), .T_CKE(T_CKE), .LW(LW)
  ) u_low (
    .clk(clk), .rst_n(rst_n), .cke_q(cke_q), .cke_fall(cke_fall),
    .settle_ok(settle_ok), .lowmin_ok(lowmin_ok), .low_cycles(low_cycles)
  );

  pd_ctrl_fsm #(.NBANK(NBANK)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pd_req(pd_req), .exit_req(exit_req), .fchg_req(fchg_req),
    .fchg_done(fchg_done), .pre_req(pre_req), .pre_all(pre_all),
    .mrs_req(mrs_req), .mrs_sel(mrs_sel), .odt_req(odt_req),
    .bank_open(bank_open), .entry_ok(entry_ok), .lm_ok(lm_ok),
    .settle_ok(settle_ok), .lowmin_ok(lowmin_ok),
    .cmd_d(cmd_d), .cke_fall(cke_fall), .state(state),
    .cmd_q(cmd_q), .all_q(all_q), .sel_q(sel_q), .cke_q(cke_q),
    .odt_q(odt_q), .go_q(go_q), .err_q(err_q)
  );

  assign cmd      = cmd_q;
  assign cmd_all  = all_q;
  assign cmd_sel  = sel_q;
  assign cke      = cke_q;
  assign odt      = odt_q;
  assign fchg_go  = go_q;
  assign fchg_err = err_q;

  // R7
  go_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> (!cke_q && (int'(low_cycles) > T_SETTLE)));

  // R9
  rise_after_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_q) |-> $past(lowmin_ok));

  // R4
  fall_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_q) |-> $past((bank_open == '0) && entry_ok));

  // R8
  err_outside_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(state) != ST_PD));

endmodule

// File: tb/pd_clk_seq_tb.sv
module pd_clk_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, P_RP = 3, P_MRD = 2, P_PREPD = 1, P_SET = 2, P_CKE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_req = 0, exit_req = 0, fchg_req = 0, fchg_done = 0;
  logic pre_req = 0, pre_all = 0, mrs_req = 0, odt_req = 0;
  logic [1:0] mrs_sel = 2'b00;
  logic [NB-1:0] bank_open = '0;
  logic [1:0] cmd, cmd_sel;
  logic cmd_all, cke, odt, fchg_go, fchg_err;

  int checks = 0, errors = 0;
  bit finished = 0, live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_clk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .exit_req(exit_req),
    .fchg_req(fchg_req), .fchg_done(fchg_done), .pre_req(pre_req),
    .pre_all(pre_all), .mrs_req(mrs_req), .mrs_sel(mrs_sel),
    .odt_req(odt_req), .bank_open(bank_open), .cmd(cmd), .cmd_all(cmd_all),
    .cmd_sel(cmd_sel), .cke(cke), .odt(odt), .fchg_go(fchg_go),
    .fchg_err(fchg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: absolute cycle numbers, states as plain integers
  // 0 idle, 1 waiting for entry, 2 powered down, 3 settling, 4 changing, 5 leaving
  int m_st, m_cmd, m_all, m_sel, m_cke, m_odt, m_go, m_err;
  int cyc, last_kind, last_at, fell_at;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cmd = 0; m_all = 0; m_sel = 0; m_cke = 1; m_odt = 0;
      m_go = 0; m_err = 0; cyc = 0; last_kind = 0; last_at = -1000;
      fell_at = -1000;
    end else begin
      int n, ncmd, nst, ncke, nodt, ngo;
      bit enter_ok, lmr_ok;
      n = cyc + 1;
      ncmd = 0; nst = m_st; ncke = m_cke; nodt = 0; ngo = m_go;
      enter_ok = (last_kind == 1) ? (n - last_at >= P_PREPD) :
                 (last_kind == 2) ? (n - last_at >= P_MRD) : 1'b1;
      lmr_ok = (last_kind != 1) || (n - last_at >= P_RP);
      m_err = (fchg_req && m_st != 2) ? 1 : 0;
      if (m_st == 0) begin
        nodt = odt_req;
        if (pre_req) ncmd = 1;
        else if (mrs_req && lmr_ok) ncmd = 2;
        if (pd_req) begin nst = 1; nodt = 0; end
      end else if (m_st == 1) begin
        if (exit_req) nst = 0;
        else if (bank_open == 0 && enter_ok) begin
          nst = 2; ncke = 0; fell_at = n;
        end
      end else if (m_st == 2) begin
        if (fchg_req) nst = 3;
        else if (exit_req) nst = 5;
      end else if (m_st == 3) begin
        if (n - fell_at >= P_SET) begin ngo = 1; nst = 4; end
      end else if (m_st == 4) begin
        if (fchg_done) begin ngo = 0; nst = 5; end
      end else begin
        if (n - fell_at >= P_CKE) begin ncke = 1; nst = 0; end
      end
      m_all = (ncmd == 1) ? int'(pre_all) : 0;
      m_sel = (ncmd == 2) ? int'(mrs_sel) : 0;
      if (ncmd != 0) begin last_kind = ncmd; last_at = n; end
      m_cmd = ncmd; m_st = nst; m_cke = ncke; m_odt = nodt; m_go = ngo;
      cyc = n;
    end
  end

  always @(negedge clk) begin
    if (live && !finished) begin
      chk("R2 cmd vs model", int'(cmd), m_cmd);
      chk("R2 cmd_all vs model", int'(cmd_all), m_all);
      chk("R2 cmd_sel vs model", int'(cmd_sel), m_sel);
      chk("R4 cke vs model", int'(cke), m_cke);
      chk("R5 odt vs model", int'(odt), m_odt);
      chk("R7 fchg_go vs model", int'(fchg_go), m_go);
      chk("R8 fchg_err vs model", int'(fchg_err), m_err);
    end
  end

  task automatic nclk(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_cke(input logic v, output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (cke !== v && k < 100);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
      $finish;
    end
  end

  initial begin
    int k;
    nclk(3);
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cke", int'(cke), 1);
    chk("R1 odt", int'(odt), 0);
    chk("R1 cmd", int'(cmd), 0);
    chk("R1 go", int'(fchg_go), 0);
    chk("R1 err", int'(fchg_err), 0);

    // R5 odt follows request in idle
    odt_req = 1; nclk(2);
    chk("R5 odt idle", int'(odt), 1);
    odt_req = 0; nclk(1);

    // R2 / R3 precharge then held mode-load request
    pre_req = 1; pre_all = 1; nclk(1);
    pre_req = 0; pre_all = 0;
    chk("R2 pre code", int'(cmd), 1);
    chk("R2 pre all", int'(cmd_all), 1);
    mrs_req = 1; mrs_sel = 2'b11;
    k = 0;
    do begin @(negedge clk); k++; end while (cmd != 2'b10 && k < 20);
    mrs_req = 0;
    chk("R3 pre-to-lmr cycles", k, P_RP);
    chk("R2 lmr select", int'(cmd_sel), 3);
    nclk(5);

    // R2 precharge wins over mode-load
    pre_req = 1; mrs_req = 1; nclk(1);
    pre_req = 0; mrs_req = 0;
    chk("R2 priority", int'(cmd), 1);
    nclk(4);

    // R4 banks open hold off entry
    bank_open = 4'b0010; pd_req = 1; nclk(1);
    pd_req = 0; nclk(5);
    chk("R4 held by open bank", int'(cke), 1);
    chk("R5 odt off while waiting", int'(odt), 0);
    bank_open = '0; nclk(1);
    chk("R4 fall after banks close", int'(cke), 0);

    // R6 commands suppressed while low
    pre_req = 1; mrs_req = 1;
    for (int i = 0; i < 3; i++) begin
      nclk(1);
      chk("R6 nop while low", int'(cmd), 0);
    end
    pre_req = 0; mrs_req = 0;

    // R7 / R9 change with exit requested during it
    fchg_req = 1; nclk(1);
    fchg_req = 0;
    k = 0;
    while (!fchg_go && k < 20) begin nclk(1); k++; end
    chk("R7 go raised", int'(fchg_go), 1);
    exit_req = 1; nclk(5);
    chk("R9 exit ignored cke", int'(cke), 0);
    chk("R9 exit ignored go", int'(fchg_go), 1);
    exit_req = 0; fchg_done = 1; nclk(1);
    fchg_done = 0;
    chk("R7 go dropped", int'(fchg_go), 0);
    nclk(1);
    chk("R9 rise after done", int'(cke), 1);
    nclk(4);

    // R4 / R7 / R9 same-cycle mode-load with entry, done with first go
    mrs_req = 1; mrs_sel = 2'b01; pd_req = 1;
    wait_cke(1'b0, k);
    mrs_req = 0; pd_req = 0;
    chk("R4 lmr to low", k, 1 + P_MRD);
    fchg_req = 1; k = 0;
    do begin @(negedge clk); fchg_req = 0; k++; end while (!fchg_go && k < 20);
    chk("R7 settle cycles", k, P_SET);
    fchg_done = 1;
    wait_cke(1'b1, k);
    fchg_done = 0;
    chk("R9 min low time", k, P_CKE - P_SET);
    nclk(3);

    // R8 frequency request outside power-down
    fchg_req = 1; nclk(1);
    fchg_req = 0;
    chk("R8 err pulse", int'(fchg_err), 1);
    chk("R8 cke untouched", int'(cke), 1);
    nclk(1);
    chk("R8 err one cycle", int'(fchg_err), 0);

    // R10 cancel while waiting
    bank_open = 4'b0001; pd_req = 1; nclk(1);
    pd_req = 0; nclk(2);
    exit_req = 1; nclk(1);
    exit_req = 0; bank_open = '0; nclk(3);
    chk("R10 cke stays high", int'(cke), 1);
    odt_req = 1; nclk(1);
    chk("R10 back in idle odt", int'(odt), 1);
    odt_req = 0; nclk(2);

    // R9 plain exit right after entry
    pd_req = 1;
    wait_cke(1'b0, k);
    pd_req = 0; exit_req = 1;
    wait_cke(1'b1, k);
    exit_req = 0;
    chk("R9 plain exit low run", k, P_CKE);
    nclk(4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule